// File: doc/BRIEF.md
# SPI Interrupt Status and Enable Register Bank

This block is the interrupt front end of a serial peripheral interface controller. Four event sources from the rest of the peripheral feed it: a mode-fault pulse, the transmit queue level, a transmit-full flag and a receive-not-empty flag. It turns them into latched status bits. Software clears status bits by writing ones to them. Software controls which bits may raise the single level interrupt line through a mask. The mask is never written directly: one address sets mask bits, another clears them, and a third, read-only address returns the mask.

The block also holds the transmit watermark. The "transmit below watermark" event is true whenever the transmit level is strictly less than this programmable value. Access is through a plain register port: a valid strobe with a write flag, an 8-bit byte address and 32-bit data. The port accepts a request on every cycle and never applies back-pressure. A read returns its data with a valid strobe exactly one cycle later. Every status or mask register uses a 7-bit layout. Status bits 0, 5 and 6 have no source in this block and always read zero. Mask bits 0, 5 and 6 exist and can be set and cleared.

Top module: `irq_ctrl_regs`

## Requirements
- R1: A read request (valid=1, write=0) is answered by rd_valid=1 on the next cycle, carrying the register value as it stood at the request edge. rd_valid is 0 in every other cycle. A write takes effect at the edge where it is presented.
- R2: Bits 31..7 of status and mask reads are zero. Reads of the enable (0x08) and disable (0x0C) addresses return 0. Writes to the mask address (0x10) and write-data bits above bit 6 have no effect.
- R3: A write to status (0x04) clears exactly the status bits written as 1. Bits written as 0 keep their value.
- R4: A source that is active at an edge sets its status bit at that edge. This holds even when the same edge writes a 1 to clear that bit, so a source that stays active reappears at once after a clear.
- R5: Writing to enable (0x08) sets every mask bit written as 1. Writing to disable (0x0C) clears every mask bit written as 1. Bits written as 0 leave the mask unchanged. Mask (0x10) reads the mask.
- R6: irq is 1 exactly when some status bit and its mask bit are both 1. The line stays high until software clears the status bit or the mask bit.
- R7: The status bit positions are: bit 1 for mode fault, bit 2 for transmit level below watermark, bit 3 for transmit full, and bit 4 for receive not empty. Bits 0, 5 and 6 always read 0.
- R8: The watermark register (0x28) resets to 1 and is read/write on its low 8 bits. Bit 2 sets when tx_level < watermark, and does not set when the level is equal to or above the watermark.
- R9: After reset, status and mask read 0 and irq is 0.
- R10: With all sources idle, writing 0x7F to disable and then 0x7F to status leaves both registers at 0 and irq at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request strobe, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| evt_mode_fault | input | 1 | Mode-fault event |
| tx_full | input | 1 | Transmit queue full |
| rx_not_empty | input | 1 | Receive queue holds data |
| tx_level | input | 8 | Current transmit queue fill level |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check several rules on every cycle. Clears and sets of status and mask bits act only on the bits written as one, and an active source always lands in status. The read strobe follows a read request by exactly one cycle. Upper read bits stay zero, and irq cannot rise without some mask bit set or fall without a write. The bench scenarios cover what a single-cycle property cannot show. These are the exact register values after sequences of operations, a clear presented together with an active source, the watermark comparison at equality, writes that have no effect on the read-only and upper-bit paths, and the full initialisation sequence.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int IRQ_W = 7;

  localparam logic [7:0] OFS_STATUS  = 8'h04;
  localparam logic [7:0] OFS_ENABLE  = 8'h08;
  localparam logic [7:0] OFS_DISABLE = 8'h0C;
  localparam logic [7:0] OFS_MASK    = 8'h10;
  localparam logic [7:0] OFS_WMARK   = 8'h28;

  localparam int BIT_MODE_FAULT = 1;
  localparam int BIT_TX_BELOW   = 2;
  localparam int BIT_TX_FULL    = 3;
  localparam int BIT_RX_AVAIL   = 4;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status_o
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_eff) | evt;
  end

  // R3: a bit cleared with no competing event is gone after the edge
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_o & $past(clr_bits & ~evt)) == '0));

  // R4: every active source is visible in status after the edge
  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_o & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] set_eff, clr_eff;
  assign set_eff = set_we ? wbits : '0;
  assign clr_eff = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= (mask_o | set_eff) & ~clr_eff;
  end

  // R5: enable writes set exactly the chosen bits, others unchanged
  p_enable_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (mask_o == ($past(mask_o) | $past(wbits))));

  // R5: disable writes clear exactly the chosen bits
  p_disable_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (mask_o == ($past(mask_o) & ~$past(wbits))));

  // R5: no write, no change
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_o));
endmodule

// File: rtl/irq_tx_watermark.sv
module irq_tx_watermark #(
  parameter int LVL_W = 8,
  parameter logic [LVL_W-1:0] RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LVL_W-1:0] wdata,
  input  logic [LVL_W-1:0] level_i,
  output logic [LVL_W-1:0] wm_o,
  output logic             below_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wm_o <= RST_VAL;
    else if (we) wm_o <= wdata;
  end

  assign below_o = level_i < wm_o;

  // R8: the watermark only moves on a write to it
  p_wm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wm_o));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TXL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_mode_fault,
  input  logic              tx_full,
  input  logic              rx_not_empty,
  input  logic [TXL_W-1:0]  tx_level,
  output logic              irq
);
  localparam int PAD_IRQ = DATA_W - IRQ_W;
  localparam int PAD_WM  = DATA_W - TXL_W;

  logic wr_req, rd_req;
  assign wr_req = bus_valid &  bus_write;
  assign rd_req = bus_valid & ~bus_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic we_status, we_enable, we_disable, we_wm;
  assign we_status  = wr_req & hit(bus_addr, OFS_STATUS);
  assign we_enable  = wr_req & hit(bus_addr, OFS_ENABLE);
  assign we_disable = wr_req & hit(bus_addr, OFS_DISABLE);
  assign we_wm      = wr_req & hit(bus_addr, OFS_WMARK);

  logic [IRQ_W-1:0] wbits;
  assign wbits = bus_wdata[IRQ_W-1:0];

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:TXL_W];

  logic [TXL_W-1:0] wm_q;
  logic             tx_below;

  irq_tx_watermark #(.LVL_W(TXL_W), .RST_VAL(TXL_W'(1))) u_wm (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we_wm),
    .wdata   (bus_wdata[TXL_W-1:0]),
    .level_i (tx_level),
    .wm_o    (wm_q),
    .below_o (tx_below)
  );

  logic [IRQ_W-1:0] evt;
  always_comb begin
    evt = '0;
    evt[BIT_MODE_FAULT] = evt_mode_fault;
    evt[BIT_TX_BELOW]   = tx_below;
    evt[BIT_TX_FULL]    = tx_full;
    evt[BIT_RX_AVAIL]   = rx_not_empty;
  end

  logic [IRQ_W-1:0] status_q, mask_q;

  irq_status_bank #(.W(IRQ_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .clr_we   (we_status),
    .clr_bits (wbits),
    .status_o (status_q)
  );

  irq_mask_bank #(.W(IRQ_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (we_enable),
    .clr_we (we_disable),
    .wbits  (wbits),
    .mask_o (mask_q)
  );

  assign irq = |(status_q & mask_q);

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFS_STATUS))     rd_mux = {{PAD_IRQ{1'b0}}, status_q};
    else if (hit(bus_addr, OFS_MASK))  rd_mux = {{PAD_IRQ{1'b0}}, mask_q};
    else if (hit(bus_addr, OFS_WMARK)) rd_mux = {{PAD_WM{1'b0}}, wm_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end

  // R1: read strobe exactly one cycle after a read request, never otherwise
  p_rd_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R2: register reads other than the watermark carry no upper bits
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(bus_addr) != ADDR_W'(OFS_WMARK)) |-> (rd_data[DATA_W-1:IRQ_W] == '0));

  // R6: irq needs an enabled bit, and only a write can drop it
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_req) |=> irq);
endmodule

// File: tb/irq_ctrl_regs_tb.sv
`timescale 1ns/1ps
module irq_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        evt_mode_fault = 1'b0, tx_full = 1'b0, rx_not_empty = 1'b0;
  logic [7:0]  tx_level = 8'd4;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .evt_mode_fault(evt_mode_fault), .tx_full(tx_full),
    .rx_not_empty(rx_not_empty), .tx_level(tx_level), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected rd_valid", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(req);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    bus_rd(8'h04, 32'h0, "R9 status after reset");
    bus_rd(8'h10, 32'h0, "R9 mask after reset");
    bus_rd(8'h28, 32'h1, "R8 watermark reset value");
    bus_rd(8'h08, 32'h0, "R2 enable reads zero");
    bus_rd(8'h0C, 32'h0, "R2 disable reads zero");

    // mode fault pulse, masked
    @(negedge clk); evt_mode_fault = 1'b1;
    @(negedge clk); evt_mode_fault = 1'b0;
    bus_rd(8'h04, 32'h02, "R7 mode fault at bit 1");
    chk("R6 masked status gives no irq", {31'd0, irq}, 32'd0);

    bus_wr(8'h08, 32'h02);
    chk("R6 irq rises when enabled", {31'd0, irq}, 32'd1);
    bus_rd(8'h10, 32'h02, "R5 enable sets mask");

    bus_wr(8'h04, 32'h0);
    bus_rd(8'h04, 32'h02, "R3 zero write keeps status");
    bus_wr(8'h04, 32'hFFFF_FF80);
    bus_rd(8'h04, 32'h02, "R2 upper write bits ignored");
    bus_wr(8'h10, 32'h7F);
    bus_rd(8'h10, 32'h02, "R2 mask address is read-only");
    chk("R6 irq held while pending", {31'd0, irq}, 32'd1);

    bus_wr(8'h04, 32'h02);
    chk("R6 irq drops after clear", {31'd0, irq}, 32'd0);
    bus_rd(8'h04, 32'h0, "R3 status cleared");

    // level sources
    @(negedge clk); rx_not_empty = 1'b1; tx_full = 1'b1;
    idle(1);
    bus_rd(8'h04, 32'h18, "R7 tx full bit 3 and rx bit 4");
    chk("R6 unmasked level sources no irq", {31'd0, irq}, 32'd0);
    bus_wr(8'h08, 32'h01);
    bus_rd(8'h10, 32'h03, "R5 zero bits of enable keep mask");
    bus_wr(8'h0C, 32'h02);
    bus_rd(8'h10, 32'h01, "R5 disable clears mask bit");
    bus_wr(8'h04, 32'h18);
    bus_rd(8'h04, 32'h18, "R4 held sources reappear after clear");
    @(negedge clk); tx_full = 1'b0;
    bus_wr(8'h04, 32'h08);
    bus_rd(8'h04, 32'h10, "R3 clears only written bit");

    // event and clear in the same cycle
    @(negedge clk);
    evt_mode_fault = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h02;
    @(negedge clk);
    evt_mode_fault = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_rd(8'h04, 32'h12, "R4 event wins over clear");
    bus_wr(8'h08, 32'h02);
    chk("R6 irq with mode fault enabled", {31'd0, irq}, 32'd1);

    // watermark
    bus_wr(8'h28, 32'h06);
    idle(1);
    bus_rd(8'h28, 32'h06, "R8 watermark write readback");
    bus_rd(8'h04, 32'h16, "R8 level 4 below watermark 6 sets bit 2");

    // initialisation with sources idle
    @(negedge clk); tx_level = 8'd10; rx_not_empty = 1'b0;
    idle(1);
    bus_wr(8'h0C, 32'h7F);
    chk("R10 irq off after disable all", {31'd0, irq}, 32'd0);
    bus_wr(8'h04, 32'h7F);
    bus_rd(8'h04, 32'h0, "R10 status cleared");
    bus_rd(8'h10, 32'h0, "R10 mask cleared");

    // watermark boundary
    @(negedge clk); tx_level = 8'd6;
    idle(2);
    bus_rd(8'h04, 32'h0, "R8 level equal to watermark no event");
    @(negedge clk); tx_level = 8'd5;
    idle(1);
    bus_rd(8'h04, 32'h04, "R8 level one below watermark");

    idle(3);
    chk("R1 all reads answered", exp_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule